// File: doc/BRIEF.md
# Multi-Mode Prescaled Reload Timer

An 8-bit down counter driven by an 8-bit down-counting prescaler. Both reload from their own reload values when they pass zero and keep counting. The count source comes from one of four internal clock-enable taps. Each tap is a one-cycle-wide strobe. In event mode the counter instead steps on edges of an external input, which is first brought into the clock domain through two flip-flops. A run bit starts and stops counting. Stopping keeps the count where it is.

Five operating modes share the one prescaler/counter pair:

- plain reload timing;
- pulse output, with a toggle output and an optional inverted companion output;
- external event counting;
- pulse width measurement, where counting is gated by the input level;
- pulse period measurement, where each active edge copies the count into a read buffer and restarts the counter.

Measurement modes keep two sticky flags, one for a captured edge and one for an underflow. Software clears each flag by writing 0 to it. A registered interrupt request pulses for one cycle on counter underflow, at the end of a measured level, and on each period capture.

Software uses a four-entry register file with a one-cycle write strobe and a combinational read port:

| Address | Write | Read |
|---|---|---|
| 0 (control) | bit 7 run, bit 6 complementary-output enable, bit 5 polarity, bits 4:3 source select, bits 2:0 mode | the control byte |
| 1 | prescaler reload value | current prescaler count |
| 2 | counter reload value | current counter, or the capture buffer in period mode |
| 3 (status) | writing 0 to a flag bit clears it | bit 0 edge flag, bit 1 underflow flag |

Mode codes: 0 timer, 1 pulse, 2 event, 3 width, 4 period.

Source codes: 0 every cycle, 1 `tick_div2_i`, 2 `tick_div8_i`, 3 `tick_alt_i`.

Polarity: 0 selects the rising edge and the high level; 1 selects the falling edge and the low level.

Top module: `mm_timer`

## Requirements
- R1: After reset the control byte reads 0, both reload values and both counts read 0xFF, the status reads 0, and `out_o`, `out_n_o` and `irq_o` are 0.
- R2: Source code 0 steps the prescaler every cycle, and codes 1, 2 and 3 step it only when `tick_div2_i`, `tick_div8_i` or `tick_alt_i` is high.
- R3: In timer mode, with prescaler reload P and counter reload C, the counter underflows and `irq_o` pulses once every (P+1)*(C+1) source ticks, indefinitely.
- R4: In pulse mode `out_o` inverts on every counter underflow.
- R5: In pulse mode with the complementary enable at 1, `out_n_o` is the inverse of `out_o`. Otherwise `out_n_o` is 0.
- R6: In event mode the counter decrements once per active edge of `ext_i` (per the polarity bit), the opposite edge has no effect, and passing zero reloads the counter and raises `irq_o`.
- R7: In width mode the prescaler steps only while the synchronized input is at the selected level, so a level lasting L cycles with P=0 lowers the counter by L. `irq_o` pulses when that level ends.
- R8: In period mode each active edge copies the counter into the buffer read at address 2 and reloads the counter. With P=0, C=255 and edges T cycles apart, the buffer reads 256-T.
- R9: In width and period modes a counter underflow sets status bit 1, and a period capture sets status bit 0. A flag clears only when 0 is written to its bit, and writing 1 leaves it unchanged.
- R10: With run at 0 the counter and prescaler hold their values.
- R11: A write to a reload value while run is 0 also loads the matching count at once. While running, the write changes only the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_div2_i | input | 1 | Clock enable, one cycle in two |
| tick_div8_i | input | 1 | Clock enable, one cycle in eight |
| tick_alt_i | input | 1 | Alternate clock enable |
| ext_i | input | 1 | External event / measurement input |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| out_o | output | 1 | Toggle output |
| out_n_o | output | 1 | Complementary output |
| irq_o | output | 1 | Interrupt request, one-cycle pulse |

## Verification
The bench sweeps every source tap against small prescaler and counter reloads and times the gap between interrupts. An off-by-one in either reload shows up as a period that misses (P+1)*(C+1) ticks. Width and period runs use several input lengths with known synchronizer latency. A gate sampled at the wrong stage or a capture taken after the reload gives a count off by one, or a buffer fixed at the reload value. Edge polarity, flag clear-by-zero, stop-hold and load-while-stopped are each probed through the read port, where a design that treats a written 1 as a clear, or counts while stopped, reads back the wrong value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    MODE_TIMER  = 3'd0,
    MODE_PULSE  = 3'd1,
    MODE_EVENT  = 3'd2,
    MODE_WIDTH  = 3'd3,
    MODE_PERIOD = 3'd4
  } tmr_mode_e;

  typedef struct packed {
    logic      run;
    logic      comp_en;
    logic      pol;
    logic [1:0] src;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PSC  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;
endpackage

// File: rtl/tmr_in_cond.sv
module tmr_in_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic act_edge_o,
  output logic end_edge_o
);
  logic s1_q, s2_q, s3_q;
  logic act, prev_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // polarity folds the selected level/edge onto "active high"
  assign act        = s2_q ^ pol_i;
  assign prev_act   = s3_q ^ pol_i;
  assign lvl_o      = act;
  assign act_edge_o = act & ~prev_act;
  assign end_edge_o = ~act & prev_act;
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         restart_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;

  assign uf_o  = step_i & ~restart_i & ~load_i & (cnt_q == '0);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '1;
    else if (load_i)    cnt_q <= load_val_i;
    else if (restart_i) cnt_q <= reload_i;
    else if (step_i)    cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - W'(1);
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] cnt_i,
  input  logic         set_uf_i,
  input  logic         stat_wr_i,
  input  logic [1:0]   stat_keep_i,
  output logic [W-1:0] buf_o,
  output logic         edge_flag_o,
  output logic         uf_flag_o
);
  logic [W-1:0] buf_q;
  logic edge_q, uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      edge_q <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      if (cap_i) buf_q <= cnt_i;
      // set wins over a same-cycle clear; a written 1 keeps the flag
      edge_q <= cap_i    | (edge_q & (~stat_wr_i | stat_keep_i[0]));
      uf_q   <= set_uf_i | (uf_q   & (~stat_wr_i | stat_keep_i[1]));
    end
  end

  assign buf_o       = buf_q;
  assign edge_flag_o = edge_q;
  assign uf_flag_o   = uf_q;
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import tmr_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_div2_i,
  input  logic       tick_div8_i,
  input  logic       tick_alt_i,
  input  logic       ext_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       out_o,
  output logic       out_n_o,
  output logic       irq_o
);
  localparam int NTAP = 4;

  tmr_ctrl_t        ctrl_q;
  logic [PSC_W-1:0] psc_rld_q, psc_cnt;
  logic [CNT_W-1:0] cnt_rld_q, cnt_q, buf_q;
  logic             psc_uf, cnt_uf;
  logic             lvl, act_edge, end_edge;
  logic             edge_flag, uf_flag;
  logic             tff_q, irq_q;
  logic [NTAP-1:0]  taps;
  logic             tick, run;
  logic             is_pulse, is_event, is_width, is_period, is_meas;
  logic             wr_ctrl, wr_psc, wr_cnt, wr_stat;
  logic             psc_step, cnt_step, cnt_restart, irq_d;

  assign wr_ctrl = wr_en_i & (wr_addr_i == ADDR_CTRL);
  assign wr_psc  = wr_en_i & (wr_addr_i == ADDR_PSC);
  assign wr_cnt  = wr_en_i & (wr_addr_i == ADDR_CNT);
  assign wr_stat = wr_en_i & (wr_addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      psc_rld_q <= '1;
      cnt_rld_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q    <= tmr_ctrl_t'(wr_data_i);
      if (wr_psc)  psc_rld_q <= wr_data_i[PSC_W-1:0];
      if (wr_cnt)  cnt_rld_q <= wr_data_i[CNT_W-1:0];
    end
  end

  assign run       = ctrl_q.run;
  assign is_pulse  = ctrl_q.mode == MODE_PULSE;
  assign is_event  = ctrl_q.mode == MODE_EVENT;
  assign is_width  = ctrl_q.mode == MODE_WIDTH;
  assign is_period = ctrl_q.mode == MODE_PERIOD;
  assign is_meas   = is_width | is_period;

  assign taps = {tick_alt_i, tick_div8_i, tick_div2_i, 1'b1};
  assign tick = taps[ctrl_q.src];

  tmr_in_cond u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext_i),
    .pol_i      (ctrl_q.pol),
    .lvl_o      (lvl),
    .act_edge_o (act_edge),
    .end_edge_o (end_edge)
  );

  assign psc_step    = run & ~is_event & tick & (~is_width | lvl);
  assign cnt_restart = run & is_period & act_edge;
  assign cnt_step    = is_event ? (run & act_edge) : psc_uf;

  tmr_down_cnt #(.W(PSC_W)) u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (psc_step),
    .restart_i  (1'b0),
    .load_i     (wr_psc & ~run),
    .load_val_i (wr_data_i[PSC_W-1:0]),
    .reload_i   (psc_rld_q),
    .cnt_o      (psc_cnt),
    .uf_o       (psc_uf)
  );

  tmr_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (cnt_step),
    .restart_i  (cnt_restart),
    .load_i     (wr_cnt & ~run),
    .load_val_i (wr_data_i[CNT_W-1:0]),
    .reload_i   (cnt_rld_q),
    .cnt_o      (cnt_q),
    .uf_o       (cnt_uf)
  );

  tmr_capture #(.W(CNT_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cnt_restart),
    .cnt_i       (cnt_q),
    .set_uf_i    (cnt_uf & is_meas),
    .stat_wr_i   (wr_stat),
    .stat_keep_i (wr_data_i[1:0]),
    .buf_o       (buf_q),
    .edge_flag_o (edge_flag),
    .uf_flag_o   (uf_flag)
  );

  assign irq_d = cnt_uf | cnt_restart | (is_width & run & end_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tff_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (is_pulse & cnt_uf) tff_q <= ~tff_q;
    end
  end

  assign out_o   = is_pulse & tff_q;
  assign out_n_o = is_pulse & ctrl_q.comp_en & ~tff_q;
  assign irq_o   = irq_q;

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL: rd_data_o = ctrl_q;
      ADDR_PSC:  rd_data_o = DATA_W'(psc_cnt);
      ADDR_CNT:  rd_data_o = is_period ? DATA_W'(buf_q) : DATA_W'(cnt_q);
      default:   rd_data_o = {6'b0, uf_flag, edge_flag};
    endcase
  end
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic             run_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [7:0]       wr_data_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cnt_rld_i,
  input logic             cnt_uf_i,
  input logic             act_edge_i,
  input logic [CNT_W-1:0] buf_i,
  input logic             edge_flag_i,
  input logic             out_i
);
  logic wr_cnt;
  assign wr_cnt = wr_en_i & (wr_addr_i == ADDR_CNT);

  a_r10_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt) |=> $stable(cnt_i));

  a_r6_event_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'(MODE_EVENT) && !act_edge_i && !wr_cnt) |=> $stable(cnt_i));

  a_r8_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'(MODE_PERIOD) && run_i && act_edge_i)
      |=> (cnt_i == $past(cnt_rld_i) && buf_i == $past(cnt_i)));

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'(MODE_PULSE) && cnt_uf_i && !wr_en_i) |=> (out_i != $past(out_i)));

  a_r9_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_flag_i && !(wr_en_i && wr_addr_i == ADDR_STAT && !wr_data_i[0])) |=> edge_flag_i);
endmodule

bind mm_timer mm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (ctrl_q.mode),
  .run_i       (ctrl_q.run),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .cnt_i       (cnt_q),
  .cnt_rld_i   (cnt_rld_q),
  .cnt_uf_i    (cnt_uf),
  .act_edge_i  (act_edge),
  .buf_i       (buf_q),
  .edge_flag_i (edge_flag),
  .out_i       (out_o)
);

// File: tb/mm_timer_tb.sv
`timescale 1ns/1ps
module mm_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       out, out_n, irq;
  logic [2:0] div_cnt = '0;
  logic       t2, t8, ta;
  int nchk = 0, nfail = 0, irq_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) div_cnt <= div_cnt + 3'd1;
  assign t2 = div_cnt[0] == 1'b0;
  assign t8 = div_cnt == 3'd0;
  assign ta = div_cnt[1:0] == 2'd0;
  always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  mm_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_div2_i(t2), .tick_div8_i(t8), .tick_alt_i(ta),
    .ext_i(ext), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .out_o(out), .out_n_o(out_n), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    rd_addr = a;
    #0.5;
    d = int'(rd_data);
  endtask

  function automatic logic [7:0] mk(input bit run, input bit comp, input bit pol,
                                    input int src, input int mode);
    return {run, comp, pol, 2'(src), 3'(mode)};
  endfunction

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 3000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, n, a, b, prev;
    int divs[4] = '{1, 2, 8, 4};
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 psc", v, 255);
    rd(2, v); chk("R1 cnt", v, 255);
    rd(3, v); chk("R1 stat", v, 0);
    chk("R1 outs", {out, out_n, irq}, 0);

    // R2/R3 timer sweep over sources and reloads; R11 load while stopped
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 3; p++)
        for (int c = 0; c < 4; c++) begin
          wr(0, mk(0, 0, 0, s, 0));
          wr(1, 8'(p));
          wr(2, 8'(c));
          rd(2, v); chk("R11 load cnt", v, c);
          wr(0, mk(1, 0, 0, s, 0));
          wait_irq(n);
          wait_irq(n);
          chk($sformatf("R2 R3 src%0d p%0d c%0d", s, p, c), n, (p + 1) * (c + 1) * divs[s]);
        end

    // R4/R5 pulse mode
    wr(0, mk(0, 1, 0, 0, 1));
    wr(1, 8'd1); wr(2, 8'd2);
    wr(0, mk(1, 1, 0, 0, 1));
    wait_irq(n);
    prev = int'(out);
    chk("R5 comp", int'(out_n), 1 - prev);
    for (int k = 0; k < 4; k++) begin
      wait_irq(n);
      chk("R4 period", n, 6);
      chk("R4 toggle", int'(out), 1 - prev);
      chk("R5 comp", int'(out_n), prev);
      prev = int'(out);
    end
    wr(0, mk(1, 0, 0, 0, 1));
    idle(2);
    chk("R5 comp off", int'(out_n), 0);

    // R6 event mode, rising edge
    wr(0, mk(0, 0, 0, 0, 2));
    wr(2, 8'd5);
    wr(0, mk(1, 0, 0, 0, 2));
    for (int k = 0; k < 3; k++) begin
      ext = 1'b1; idle(6); ext = 1'b0; idle(6);
    end
    rd(2, v); chk("R6 three edges", v, 2);
    // falling edge selected: rising ignored
    wr(0, mk(0, 0, 1, 0, 2));
    wr(2, 8'd2);
    wr(0, mk(1, 0, 1, 0, 2));
    ext = 1'b1; idle(6);
    rd(2, v); chk("R6 rising ignored", v, 2);
    a = irq_cnt;
    ext = 1'b0; idle(6);
    rd(2, v); chk("R6 falling counts", v, 1);
    for (int k = 0; k < 2; k++) begin
      ext = 1'b1; idle(6); ext = 1'b0; idle(6);
    end
    rd(2, v); chk("R6 reload after underflow", v, 2);
    chk("R6 underflow irq", irq_cnt - a, 1);

    // R7 width mode, high level
    foreach (divs[i]) begin
      int len;
      len = 5 + 12 * i;
      wr(0, mk(0, 0, 0, 0, 3));
      wr(1, 8'd0); wr(2, 8'd255);
      wr(0, mk(1, 0, 0, 0, 3));
      idle(4);
      a = irq_cnt;
      ext = 1'b1; idle(len); ext = 1'b0; idle(6);
      rd(2, v); chk($sformatf("R7 width %0d", len), v, 255 - len);
      chk("R7 end irq", irq_cnt - a, 1);
    end
    // low level
    wr(0, mk(0, 0, 1, 0, 3));
    ext = 1'b1;
    wr(2, 8'd255);
    wr(0, mk(1, 0, 1, 0, 3));
    idle(4);
    ext = 1'b0; idle(9); ext = 1'b1; idle(6);
    rd(2, v); chk("R7 low width", v, 255 - 9);
    // R9 underflow flag in width mode
    wr(0, mk(0, 0, 0, 0, 3));
    ext = 1'b0;
    wr(3, 8'd0);
    wr(2, 8'd3);
    wr(0, mk(1, 0, 0, 0, 3));
    idle(4);
    ext = 1'b1; idle(10); ext = 1'b0; idle(6);
    rd(3, v); chk("R9 width uf flag", v, 2);
    wr(3, 8'd0);

    // R8 period capture
    for (int i = 0; i < 3; i++) begin
      int tp;
      tp = (i == 0) ? 20 : (i == 1) ? 33 : 77;
      wr(0, mk(0, 0, 0, 0, 4));
      wr(1, 8'd0); wr(2, 8'd255);
      wr(0, mk(1, 0, 0, 0, 4));
      for (int k = 0; k < 3; k++) begin
        ext = 1'b1; idle(tp / 2); ext = 1'b0; idle(tp - tp / 2);
        if (k > 0) begin
          rd(2, v); chk($sformatf("R8 period %0d", tp), v, 256 - tp);
        end
      end
      rd(3, v); chk("R8 edge flag", v, 1);
    end
    // R9 underflow in period mode, then clear semantics
    wr(0, mk(0, 0, 0, 0, 4));
    wr(2, 8'd10);
    wr(0, mk(1, 0, 0, 0, 4));
    for (int k = 0; k < 2; k++) begin
      ext = 1'b1; idle(25); ext = 1'b0; idle(25);
    end
    wr(0, mk(0, 0, 0, 0, 4));
    idle(4);
    rd(3, v); chk("R9 both flags", v, 3);
    wr(3, 8'd1);
    rd(3, v); chk("R9 write1 keeps edge", v, 1);
    wr(3, 8'd2);
    rd(3, v); chk("R9 write0 clears edge", v, 0);

    // R10 stop holds, R11 running write does not load
    wr(0, mk(0, 0, 0, 0, 0));
    wr(1, 8'd0); wr(2, 8'd200);
    wr(0, mk(1, 0, 0, 0, 0));
    idle(30);
    wr(0, mk(0, 0, 0, 0, 0));
    rd(2, a); idle(20); rd(2, b);
    chk("R10 hold", b, a);
    rd(1, a); idle(5); rd(1, b);
    chk("R10 psc hold", b, a);
    wr(2, 8'd77);
    rd(2, v); chk("R11 stopped load", v, 77);
    wr(0, mk(1, 0, 0, 0, 0));
    wr(2, 8'd9);
    rd(2, v); chk("R11 running no load", int'(v > 60), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule